// File: doc/BRIEF.md
# Seven-Channel Pulse-Width Modulator Bank with Pin Multiplexing

This block holds seven pulse-width modulator channels that share one timebase. A prescaler divides the system clock into a PWM tick. One 8-bit frame counter advances on each tick and restarts every 256 ticks. Each channel compares its own 8-bit duty value against that counter. The channel output stays low while the counter has not passed the duty value, and it is high for the rest of the frame. The low time is therefore (value + 1) ticks. A value of 255 holds the output low for the whole frame.

Software writes duty values over a 16-bit register bus that has byte enables. A register changes only on a complete word write. Partial writes are dropped, and byte reads return only the enabled lanes. A write first lands in a shadow register. The frame sequencer copies every shadow into the active compare values at the moment the counter wraps from 255 to 0, so a running frame is never cut short. Each pin then goes through a multiplexer that selects either the PWM waveform or ordinary port data. A per-pin direction bit drives the output enable.

The frame sequencer is a two-state machine. In `FS_RUN` the counter is between 0 and 254. The transition `FS_RUN -> FS_LAST` happens on the tick that moves the counter to 255. In `FS_LAST` the next tick takes the transition `FS_LAST -> FS_RUN`, which zeroes the counter and pulses the shadow-to-active load.

Top module: `pwmx_bank`

## Requirements
- R1: Channel k (0..6) is reached at byte offset 2k, so offsets 0x0, 0x2 through 0xC. The register index is bus_addr[3:1]. Offset 0xE reads as zero and writes to it change nothing.
- R2: After reset, every duty register, every active compare value, the prescaler and the frame counter are zero.
- R3: A write is accepted only when bus_be is 2'b11 and bus_addr[0] is 0. Any other byte-enable pattern or an odd address leaves the register unchanged.
- R4: A read returns the last accepted value in bits 7:0 with bits 15:8 at zero. Byte lane 0 (bits 7:0) and lane 1 (bits 15:8) carry data only when bus_be[0] or bus_be[1], respectively, is set. Otherwise they read zero.
- R5: The PWM tick occurs once every DIV system clocks (default 16), beginning DIV clocks after reset.
- R6: The frame counter advances by one on each tick and wraps from 255 to 0, so a frame lasts 256 ticks.
- R7: A channel's PWM waveform is low while frame counter <= active value and high otherwise. Value 0 is low for exactly one tick per frame, and value 255 is low for the entire frame.
- R8: A written value takes effect only at the tick where the counter wraps from 255 to 0. Until then the previous value continues to drive the waveform.
- R9: pin_out[k] equals the PWM waveform of channel k when pin_sel[k] is 1, and port_data[k] when pin_sel[k] is 0.
- R10: pin_oe[k] equals pin_dir[k] whatever pin_sel[k] is.
- R11: The sequencer is in FS_LAST exactly while the frame counter holds 255. It enters FS_LAST on the tick into 255 and returns to FS_RUN on the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the block |
| bus_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| port_data | input | 7 | General-purpose port value per pin |
| pin_sel | input | 7 | 1 = PWM drives the pin, 0 = port data |
| pin_dir | input | 7 | Per-pin output-driver enable request |
| pin_out | output | 7 | Multiplexed pin value |
| pin_oe | output | 7 | Pin output enable |

## Verification
The bench builds the bank with DIV set to 2, and leaves the channel count and data width at their defaults. With that setting a full 256-tick frame lasts 512 clocks, so the run covers many counter wraps in a short time. In those wraps the bench checks that shadow values are only applied at a wrap, and that the one-tick low pulse of value 0 and the all-low frame of value 255 appear correctly. With the divider still above one, the prescaler's idle clocks between ticks are still exercised, and every pin is compared against an independent frame model on every cycle.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
    localparam int BUS_W = 16;

    typedef enum logic {
        FS_RUN  = 1'b0,
        FS_LAST = 1'b1
    } fseq_t;
endpackage

// File: rtl/pwmx_prescaler.sv
module pwmx_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV > 1) begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == LAST);

            // R5
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/pwmx_frame.sv
module pwmx_frame #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] frame,
    output logic          wrap
);
    import pwmx_pkg::*;

    localparam logic [CW-1:0] TOP     = '1;
    localparam logic [CW-1:0] TOP_M1  = TOP - 1'b1;

    fseq_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_RUN;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            FS_RUN:  if (tick && frame == TOP_M1) state_nx = FS_LAST;
            FS_LAST: if (tick)                    state_nx = FS_RUN;
            default: state_nx = FS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        wrap = (state == FS_LAST) && tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    frame <= '0;
        else if (tick) frame <= wrap ? '0 : frame + 1'b1;
    end

    // R6
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == FS_RUN) |=> frame == CW'($past(frame) + 1'b1));
    // R6
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> frame == '0);
    // R6
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(frame));
    // R11
    last_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_LAST) == (frame == TOP));
endmodule

// File: rtl/pwmx_regs.sv
module pwmx_regs #(
    parameter int NCH    = 7,
    parameter int DW     = 8,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [1:0]               bus_be,
    input  logic [pwmx_pkg::BUS_W-1:0] bus_wdata,
    output logic [pwmx_pkg::BUS_W-1:0] bus_rdata,
    input  logic                     load,
    output logic [NCH-1:0][DW-1:0]   active
);
    import pwmx_pkg::*;

    localparam int IDX_W = ADDR_W - 1;

    logic [NCH-1:0][DW-1:0] shadow;
    logic [IDX_W-1:0]       idx;
    logic                   hit;
    logic                   wr_ok;
    logic [BUS_W-1:0]       word;

    assign idx   = bus_addr[ADDR_W-1:1];
    assign hit   = int'(idx) < NCH;
    assign wr_ok = bus_sel && bus_wr && (bus_be == 2'b11) && !bus_addr[0] && hit;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              shadow[c] <= '0;
                else if (wr_ok && idx == IDX_W'(c))      shadow[c] <= bus_wdata[DW-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= shadow;
    end

    always_comb begin
        word = '0;
        if (bus_sel && !bus_wr && hit) word[DW-1:0] = shadow[idx];
        bus_rdata = word & {{(BUS_W/2){bus_be[1]}}, {(BUS_W/2){bus_be[0]}}};
    end

    // R3
    byte_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be != 2'b11) |=> $stable(shadow));
    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] frame,
    input  logic [DW-1:0] duty,
    input  logic          sel,
    input  logic          dir,
    input  logic          port_bit,
    output logic          out,
    output logic          oe
);
    logic wave;

    always_comb begin
        wave = (frame > duty);
        out  = sel ? wave : port_bit;
        oe   = dir;
    end
endmodule

// File: rtl/pwmx_bank.sv
module pwmx_bank #(
    parameter int NCH    = 7,
    parameter int DW     = 8,
    parameter int DIV    = 16,
    parameter int ADDR_W = $clog2(NCH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [NCH-1:0]    port_data,
    input  logic [NCH-1:0]    pin_sel,
    input  logic [NCH-1:0]    pin_dir,
    output logic [NCH-1:0]    pin_out,
    output logic [NCH-1:0]    pin_oe
);
    logic                   tick;
    logic                   wrap;
    logic [DW-1:0]          frame;
    logic [NCH-1:0][DW-1:0] active;

    pwmx_prescaler #(.DIV(DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pwmx_frame #(.CW(DW)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .frame (frame),
        .wrap  (wrap)
    );

    pwmx_regs #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .load      (wrap),
        .active    (active)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            pwmx_chan #(.DW(DW)) u_chan (
                .frame    (frame),
                .duty     (active[c]),
                .sel      (pin_sel[c]),
                .dir      (pin_dir[c]),
                .port_bit (port_data[c]),
                .out      (pin_out[c]),
                .oe       (pin_oe[c])
            );

            // R7
            full_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_sel[c] && active[c] == '1) |-> !pin_out[c]);
        end
    endgenerate
endmodule

// File: tb/pwmx_bank_tb.sv
`timescale 1ns/1ps
module pwmx_bank_tb;
    localparam int NCH = 7;
    localparam int DIV = 2;
    localparam int FRAME_CYC = 256 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [6:0]  port_data = 7'h33;
    logic [6:0]  pin_sel = 7'h7F;
    logic [6:0]  pin_dir = 7'h55;
    logic [6:0]  pin_out;
    logic [6:0]  pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit chk_en = 1'b0;

    // independent frame model
    int m_presc = 0;
    int m_frame = 0;
    int m_shadow [NCH];
    int m_active [NCH];

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    pwmx_bank #(.NCH(NCH), .DW(8), .DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .port_data(port_data), .pin_sel(pin_sel),
        .pin_dir(pin_dir), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_presc = 0;
            m_frame = 0;
            for (int i = 0; i < NCH; i++) begin m_shadow[i] = 0; m_active[i] = 0; end
        end else begin
            bit tk;
            tk = (m_presc == DIV - 1);
            m_presc = tk ? 0 : m_presc + 1;
            if (tk) begin
                if (m_frame == 255) begin
                    m_frame = 0;
                    for (int i = 0; i < NCH; i++) m_active[i] = m_shadow[i];
                end else m_frame = m_frame + 1;
            end
            if (bus_sel && bus_wr && bus_be == 2'b11 && !bus_addr[0] && int'(bus_addr[3:1]) < NCH)
                m_shadow[bus_addr[3:1]] = int'(bus_wdata[7:0]);
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // pin monitor, every cycle
    always @(negedge clk) begin
        #1;
        if (rst_n && chk_en && !done) begin
            for (int c = 0; c < NCH; c++) begin
                logic e;
                e = pin_sel[c] ? (m_frame > m_active[c]) : port_data[c];
                check(pin_out[c] === e, $sformatf("R6 R7 R9 pin_out[%0d]", c), pin_out[c], e);
                check(pin_oe[c] === pin_dir[c], $sformatf("R10 pin_oe[%0d]", c), pin_oe[c], pin_dir[c]);
            end
        end
    end

    // read scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (bus_sel && !bus_wr && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata === e, t, bus_rdata, e);
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [1:0] be,
                            input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int vals [NCH] = '{0, 1, 127, 128, 254, 255, 37};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;

        // R2 reset state
        for (int c = 0; c < NCH; c++) bus_read(4'(2*c), 2'b11, 16'h0, "R2 reset value");

        // R1 channel offsets
        for (int c = 0; c < NCH; c++) bus_write(4'(2*c), 2'b11, 16'(vals[c]));
        for (int c = 0; c < NCH; c++) bus_read(4'(2*c), 2'b11, 16'(vals[c]), "R1 offset map");
        bus_write(4'hE, 2'b11, 16'hFFFF);
        bus_read(4'hE, 2'b11, 16'h0, "R1 offset 0xE");

        // R3 partial writes dropped
        bus_write(4'h4, 2'b01, 16'h00AA);
        bus_write(4'h4, 2'b10, 16'hAA00);
        bus_write(4'h5, 2'b11, 16'h00AA);
        bus_write(4'h4, 2'b00, 16'h00AA);
        bus_read(4'h4, 2'b11, 16'd127, "R3 byte write ignored");

        // R4 byte reads and upper byte
        bus_read(4'h6, 2'b01, 16'h0080, "R4 low lane");
        bus_read(4'h6, 2'b10, 16'h0000, "R4 high lane");
        bus_write(4'hC, 2'b11, 16'hFF25);
        bus_read(4'hC, 2'b11, 16'h0025, "R4 upper bits zero");

        // R5 R6 R7: count high cycles over one full frame after values settle
        repeat (2 * FRAME_CYC) @(negedge clk);
        begin
            int h0, h3, h5, h1;
            h0 = 0; h3 = 0; h5 = 0; h1 = 0;
            for (int k = 0; k < FRAME_CYC; k++) begin
                @(negedge clk); #1;
                h0 += int'(pin_out[0]); h1 += int'(pin_out[1]);
                h3 += int'(pin_out[3]); h5 += int'(pin_out[5]);
            end
            check(h0 == 255 * DIV, "R5 R7 value 0 high cycles", h0, 255 * DIV);
            check(h1 == 254 * DIV, "R6 R7 value 1 high cycles", h1, 254 * DIV);
            check(h3 == 127 * DIV, "R7 value 128 high cycles", h3, 127 * DIV);
            check(h5 == 0, "R7 value 255 never high", h5, 0);
        end

        // R8 mid-frame update waits for wrap
        while (m_frame != 100) @(negedge clk);
        bus_write(4'hA, 2'b11, 16'h0000);
        repeat (4) @(negedge clk); #1;
        check(pin_out[5] === 1'b0, "R8 old value still active", pin_out[5], 0);
        while (m_frame != 3) @(negedge clk);
        #1;
        check(pin_out[5] === 1'b1, "R8 new value after wrap", pin_out[5], 1);

        // R9 R10 pin mux and direction
        @(negedge clk);
        pin_sel = 7'b0001111; pin_dir = 7'h2A; port_data = 7'b1010000;
        #1;
        check(pin_out[6:4] === port_data[6:4], "R9 port data selected", pin_out[6:4], port_data[6:4]);
        check(pin_oe === 7'h2A, "R10 oe follows dir", pin_oe, 7'h2A);
        @(negedge clk);
        port_data = 7'b0101111; pin_dir = 7'h7F;
        #1;
        check(pin_out[6:4] === 3'b010, "R9 port data toggled", pin_out[6:4], 3'b010);
        check(pin_oe === 7'h7F, "R10 oe all set", pin_oe, 7'h7F);
        repeat (FRAME_CYC) @(negedge clk);

        // R11 sequencer wrap behaviour seen at pins: value 254 high only at frame 255
        pin_sel = 7'h7F;
        while (m_frame != 255) @(negedge clk);
        #1;
        check(pin_out[4] === 1'b1, "R11 last frame slot high", pin_out[4], 1);
        while (m_frame != 0) @(negedge clk);
        #1;
        check(pin_out[4] === 1'b0, "R11 wrapped to zero", pin_out[4], 0);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule